// File: doc/BRIEF.md
# Packet Word-to-Lane Serializer with Control Insertion

This block drains 64-bit packet words from a source FIFO and emits them on a 16-bit lane, one lane word per clock. Every word arrives with sideband fields: a packet-start flag, a packet-end flag, a 3-bit count of valid bytes, an 8-bit channel number and an error flag. The lane carries a one-bit control flag that marks which cycles hold a control word and which hold payload.

Before the first payload of a packet the block inserts a start control word, and after the last payload it inserts an end control word. The end word encodes how many bytes of the final lane word are meaningful, or that the packet was aborted. When a packet end is followed at once by a new packet start, both are carried in one merged control word. When nothing is pending, idle control words fill the lane. Each control word closes with a 4-bit diagonal parity that covers that control word and every payload word sent since the previous control word.

The input side uses a valid/ready handshake. `in_ready` depends only on internal state, never on `in_valid`. A word is taken in any cycle where both are high. While the current word still has lane words to send, `in_ready` stays low, and the source must hold the word and its sidebands steady. The lane never stalls: it emits one word every cycle.

Top module: `pkt_lane_serializer`

## Requirements
- R1: A 64-bit input word is emitted as up to four consecutive 16-bit payload words, starting with bits 63:48 and ending with bits 15:0.
- R2: `lane_ctl` is 1 in every cycle that carries a control word and 0 in every cycle that carries payload.
- R3: When the accepted word has its start flag set, a control word with bit 15 = 1 and bit 12 = 1 is emitted in the cycle just before that word's first payload word.
- R4: A control word is laid out as follows: bit 15 is the type (1 only when a packet start is announced), bits 14:13 are the end status, bit 12 is the start flag, bits 11:4 are the channel number and bits 3:0 are the parity.
- R5: In the cycle after the last payload word of a word whose end flag is set, a control word is emitted with a nonzero end status and that packet's channel number. If no start follows at once, this word has type 0 and start flag 0.
- R6: On a word whose end flag is set, a byte count m of 1 to 7 means only the top m bytes are valid, and a count of 0 means all 8 bytes are valid. Only ceil(m/2) payload words are sent; the rest of the word is skipped. The low byte of a half-valid last payload word is sent as 00.
- R7: End status codes: 00 means no end, 01 means abort (the error flag is set on the end word), 10 means the last payload word holds 2 valid bytes, and 11 means it holds 1 valid byte.
- R8: The parity is computed as follows. XOR the control word (with its parity bits taken as 1111) and all payload words since the previous control word into a 16-bit value x. Parity bit i is the XOR of every x[j] for which (j + j/4) mod 4 = i.
- R9: When a start word is accepted in the same cycle as the last payload word of an end word, a single merged control word follows, carrying type 1, the end status, start flag 1 and the new channel number.
- R10: With nothing to send, the lane carries idle control words with bits 15:4 all zero. After reset the lane shows 0x000F with `lane_ctl` = 1 and `in_ready` = 1.
- R11: `in_ready` is 1 only when no word is held, or when the held word's last payload word is going out in that cycle. This lets back-to-back words of one packet stream without gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Source presents a word |
| in_ready | output | 1 | Block takes the word this cycle if valid |
| in_data | input | 64 | Packet bytes, first byte in bits 63:56 |
| in_sop | input | 1 | Word starts a packet |
| in_eop | input | 1 | Word ends a packet |
| in_mod | input | 3 | Valid byte count on an end word (0 = all 8) |
| in_chan | input | 8 | Channel number |
| in_err | input | 1 | Abort the packet this word ends |
| lane_data | output | 16 | Lane word (payload or control) |
| lane_ctl | output | 1 | Lane word is a control word |

## Verification
A wrong lane index or byte count shows at once as a payload word out of order, or as a skipped or extra lane slot. It also shifts every later control word by at least one cycle. A corrupted parity accumulator does not show until the next control word. From then on the 4 parity bits differ, even when every payload word was correct. A stale pending-end flag shows either as a missing end word right after a packet's last payload, or as an unmerged pair where a merged word belongs. The bench predicts every lane word and the ready level on every cycle, so each of these faults is caught in the cycle it first reaches the ports.

// File: rtl/pls_pkg.sv
package pls_pkg;

  typedef enum logic [1:0] {
    SEL_IDLE   = 2'd0,
    SEL_SOPCTL = 2'd1,
    SEL_ENDCTL = 2'd2,
    SEL_DATA   = 2'd3
  } lane_sel_e;

  localparam logic [1:0] ENDST_NONE  = 2'b00;
  localparam logic [1:0] ENDST_ABORT = 2'b01;
  localparam logic [1:0] ENDST_TWO   = 2'b10;
  localparam logic [1:0] ENDST_ONE   = 2'b11;

  // Bits of the 16-bit sum feeding parity bit i: diagonal grouping.
  function automatic logic [15:0] par_mask(input int i);
    logic [15:0] m;
    m = '0;
    for (int j = 0; j < 16; j++) begin
      if (((j + j / 4) % 4) == i) m[j] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/pls_lane_slicer.sv
module pls_lane_slicer #(
  parameter int WORD_W = 64,
  parameter int LANE_W = 16,
  localparam int LANES  = WORD_W / LANE_W,
  localparam int BPL    = LANE_W / 8,
  localparam int IDX_W  = $clog2(LANES),
  localparam int CNT_W  = $clog2(LANES + 1),
  localparam int MOD_W  = $clog2(WORD_W / 8),
  localparam int BCNT_W = $clog2(BPL + 1)
) (
  input  logic [WORD_W-1:0] word,
  input  logic [IDX_W-1:0]  idx,
  input  logic              eop,
  input  logic [MOD_W-1:0]  mod,
  output logic [LANE_W-1:0] lane,
  output logic [CNT_W-1:0]  nlanes,
  output logic [BCNT_W-1:0] last_bytes
);

  logic partial;
  assign partial = eop && (mod != '0);

  always_comb begin
    int nl;
    int lb;
    if (partial) begin
      nl = (int'(mod) + BPL - 1) / BPL;
      lb = int'(mod) - (nl - 1) * BPL;
    end else begin
      nl = LANES;
      lb = BPL;
    end
    nlanes     = CNT_W'(nl);
    last_bytes = BCNT_W'(lb);
  end

  always_comb begin
    lane = word[WORD_W-1 - int'(idx)*LANE_W -: LANE_W];
    for (int b = 0; b < BPL; b++) begin
      if (partial && ((int'(idx) * BPL + b) >= int'(mod)))
        lane[LANE_W-1 - b*8 -: 8] = 8'h00;
    end
  end

endmodule

// File: rtl/pls_dip_gen.sv
module pls_dip_gen #(
  parameter int LANE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_ctl,
  input  logic [LANE_W-1:0] data_word,
  input  logic [11:0]       ctl_hdr,
  output logic [3:0]        dip
);

  logic [15:0] acc;
  logic [15:0] sum;

  assign sum = acc ^ {ctl_hdr, 4'hF};

  for (genvar i = 0; i < 4; i++) begin : g_fold
    assign dip[i] = ^(sum & pls_pkg::par_mask(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      acc <= '0;
    else if (is_ctl) acc <= '0;
    else             acc <= acc ^ data_word;
  end

  // R8: a control word restarts the parity window
  a_r8_window_restart: assert property (@(posedge clk) disable iff (!rst_n)
    is_ctl |=> (acc == 16'h0));

endmodule

// File: rtl/pkt_lane_serializer.sv
module pkt_lane_serializer #(
  parameter int WORD_W = 64,
  parameter int LANE_W = 16,
  parameter int CHAN_W = 8,
  localparam int LANES  = WORD_W / LANE_W,
  localparam int BPL    = LANE_W / 8,
  localparam int IDX_W  = $clog2(LANES),
  localparam int CNT_W  = $clog2(LANES + 1),
  localparam int MOD_W  = $clog2(WORD_W / 8),
  localparam int BCNT_W = $clog2(BPL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [MOD_W-1:0]  in_mod,
  input  logic [CHAN_W-1:0] in_chan,
  input  logic              in_err,
  output logic [LANE_W-1:0] lane_data,
  output logic              lane_ctl
);
  import pls_pkg::*;

  // held word
  logic              busy;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] w_data;
  logic              w_sop_pend;
  logic              w_eop;
  logic [MOD_W-1:0]  w_mod;
  logic [CHAN_W-1:0] w_chan;
  logic              w_err;
  // end word owed to the lane
  logic              pend_eop;
  logic [1:0]        pend_st;
  logic [CHAN_W-1:0] pend_chan;

  logic [LANE_W-1:0] lane_w;
  logic [CNT_W-1:0]  nlanes;
  logic [BCNT_W-1:0] last_bytes;
  logic              last;
  lane_sel_e         sel;
  logic              issue_last;
  logic              accept;
  logic [1:0]        word_st;
  logic [11:0]       hdr;
  logic [3:0]        dip;

  pls_lane_slicer #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_slicer (
    .word       (w_data),
    .idx        (idx),
    .eop        (w_eop),
    .mod        (w_mod),
    .lane       (lane_w),
    .nlanes     (nlanes),
    .last_bytes (last_bytes)
  );

  assign last = ({1'b0, idx} == (nlanes - CNT_W'(1)));

  always_comb begin
    if (busy) begin
      if (w_sop_pend)    sel = SEL_SOPCTL;
      else if (pend_eop) sel = SEL_ENDCTL;
      else               sel = SEL_DATA;
    end else begin
      sel = pend_eop ? SEL_ENDCTL : SEL_IDLE;
    end
  end

  assign issue_last = (sel == SEL_DATA) && last;
  assign in_ready   = !busy || issue_last;
  assign accept     = in_valid && in_ready;

  always_comb begin
    if (w_err)                        word_st = ENDST_ABORT;
    else if (last_bytes == BCNT_W'(1)) word_st = ENDST_ONE;
    else                              word_st = ENDST_TWO;
  end

  always_comb begin
    unique case (sel)
      SEL_SOPCTL: hdr = {1'b1, (pend_eop ? pend_st : ENDST_NONE), 1'b1, w_chan};
      SEL_ENDCTL: hdr = {1'b0, pend_st, 1'b0, pend_chan};
      default:    hdr = '0;
    endcase
  end

  pls_dip_gen #(.LANE_W(LANE_W)) u_dip (
    .clk       (clk),
    .rst_n     (rst_n),
    .is_ctl    (lane_ctl),
    .data_word (lane_w),
    .ctl_hdr   (hdr),
    .dip       (dip)
  );

  assign lane_ctl  = (sel != SEL_DATA);
  assign lane_data = lane_ctl ? {hdr, dip} : lane_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      idx        <= '0;
      w_data     <= '0;
      w_sop_pend <= 1'b0;
      w_eop      <= 1'b0;
      w_mod      <= '0;
      w_chan     <= '0;
      w_err      <= 1'b0;
      pend_eop   <= 1'b0;
      pend_st    <= ENDST_NONE;
      pend_chan  <= '0;
    end else begin
      unique case (sel)
        SEL_SOPCTL: begin
          w_sop_pend <= 1'b0;
          pend_eop   <= 1'b0;
        end
        SEL_ENDCTL: pend_eop <= 1'b0;
        SEL_DATA: begin
          idx <= idx + IDX_W'(1);
          if (last) begin
            busy <= 1'b0;
            if (w_eop) begin
              pend_eop  <= 1'b1;
              pend_st   <= word_st;
              pend_chan <= w_chan;
            end
          end
        end
        default: ;
      endcase
      if (accept) begin
        busy       <= 1'b1;
        idx        <= '0;
        w_data     <= in_data;
        w_sop_pend <= in_sop;
        w_eop      <= in_eop;
        w_mod      <= in_mod;
        w_chan     <= in_chan;
        w_err      <= in_err;
      end
    end
  end

  // R3: an accepted start word is announced on the very next lane word
  a_r3_start_announced: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_sop) |=> (lane_ctl && lane_data[15] && lane_data[12]));

  // R5: an end word follows the last payload of an end-flagged word
  a_r5_end_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_last && w_eop) |=> (lane_ctl && (lane_data[14:13] != 2'b00)));

  // R9: back-to-back end and start share one control word
  a_r9_merged: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_last && w_eop && accept && in_sop) |=>
      (lane_data[15] && lane_data[12] && (lane_data[14:13] != 2'b00)));

  // R6: the lane index never passes the word's lane count
  a_r6_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ({1'b0, idx} < nlanes));

  // R11: a held, unfinished word is not replaced
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !in_ready) |=> ($stable(w_data) && busy));

  // R10: with nothing owed, the lane idles with a zero header
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !pend_eop) |-> (lane_ctl && (lane_data[15:4] == 12'h000)));

endmodule

// File: tb/tb_pkt_lane_serializer.sv
`timescale 1ns/1ps
module tb_pkt_lane_serializer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [63:0] in_data;
  logic        in_sop, in_eop, in_err;
  logic [2:0]  in_mod;
  logic [7:0]  in_chan;
  logic [15:0] lane_data;
  logic        lane_ctl;

  always #2.5 clk = ~clk;

  pkt_lane_serializer dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .in_mod(in_mod),
    .in_chan(in_chan), .in_err(in_err), .lane_data(lane_data), .lane_ctl(lane_ctl)
  );

  typedef struct {
    logic [63:0] d;
    bit sop, eop, err;
    bit [2:0] mod;
    bit [7:0] chan;
  } wrd_t;

  wrd_t        stim[$];
  logic [16:0] olog[$];
  int  checks = 0, fails = 0, cyc = 0;
  bit  gaps = 0, done = 0;

  // reference model state
  logic [15:0] m_lanes[$];
  bit          m_sop, m_weop, pe;
  bit [1:0]    m_wst, pst;
  bit [7:0]    m_chan, pchan;
  logic [15:0] acc = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] dip4(input logic [15:0] x);
    logic [3:0] p = '0;
    for (int j = 0; j < 16; j++) p[(j + j/4) % 4] ^= x[j];
    return p;
  endfunction

  task automatic add(input logic [63:0] d, input bit sop, input bit eop,
                     input bit [2:0] mod, input bit [7:0] chan, input bit err);
    wrd_t w;
    w.d = d; w.sop = sop; w.eop = eop; w.mod = mod; w.chan = chan; w.err = err;
    stim.push_back(w);
  endtask

  task automatic step();
    bit held, is_data, exp_rdy, take;
    logic [11:0] hdr;
    logic [15:0] exp_w;
    int n;
    @(negedge clk);
    held    = (m_lanes.size() > 0);
    is_data = 0;
    hdr     = '0;
    if (held && m_sop)   hdr = {1'b1, (pe ? pst : 2'b00), 1'b1, m_chan};
    else if (held && pe) hdr = {1'b0, pst, 1'b0, pchan};
    else if (held)       is_data = 1;
    else if (pe)         hdr = {1'b0, pst, 1'b0, pchan};
    exp_rdy = !held || (is_data && m_lanes.size() == 1);
    if (is_data) exp_w = m_lanes[0];
    else         exp_w = {hdr, dip4(acc ^ {hdr, 4'hF})};
    chk(lane_ctl == !is_data, "R2", "lane_ctl", 32'(lane_ctl), 32'(!is_data));
    chk(lane_data == exp_w, is_data ? "R1" : "R4", "lane_data", 32'(lane_data), 32'(exp_w));
    chk(in_ready == exp_rdy, "R11", "in_ready", 32'(in_ready), 32'(exp_rdy));
    olog.push_back({lane_ctl, lane_data});
    // drive this cycle's input
    if (stim.size() > 0 && !(gaps && (cyc % 4) == 2)) begin
      in_valid = 1; in_data = stim[0].d; in_sop = stim[0].sop; in_eop = stim[0].eop;
      in_mod = stim[0].mod; in_chan = stim[0].chan; in_err = stim[0].err;
    end else begin
      in_valid = 0;
    end
    take = in_valid && exp_rdy;
    // advance model
    if (is_data) begin
      acc = acc ^ m_lanes[0];
      void'(m_lanes.pop_front());
      if (m_lanes.size() == 0 && m_weop) begin pe = 1; pst = m_wst; pchan = m_chan; end
    end else begin
      acc = '0;
      if (held && m_sop) begin m_sop = 0; pe = 0; end
      else if (pe) pe = 0;
    end
    if (take) begin
      n = (stim[0].eop && stim[0].mod != 0) ? (stim[0].mod + 1) / 2 : 4;
      for (int k = 0; k < n; k++) begin
        logic [15:0] lw;
        lw = stim[0].d[63 - 16*k -: 16];
        if (k == n - 1 && stim[0].eop && stim[0].mod[0]) lw[7:0] = 8'h00;
        m_lanes.push_back(lw);
      end
      m_sop = stim[0].sop; m_weop = stim[0].eop; m_chan = stim[0].chan;
      m_wst = stim[0].err ? 2'b01 : ((stim[0].eop && stim[0].mod[0]) ? 2'b11 : 2'b10);
      void'(stim.pop_front());
    end
    cyc++;
  endtask

  task automatic drain();
    while (stim.size() > 0 || m_lanes.size() > 0 || pe) step();
    repeat (2) step();
  endtask

  function automatic int find_hdr(input logic [11:0] h);
    for (int i = 0; i < olog.size(); i++)
      if (olog[i][16] && olog[i][15:4] == h) return i;
    return -1;
  endfunction

  task automatic report();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog timeout actual=%0d expected<60000", cyc);
    report();
  end

  initial begin
    int i0, i1;
    logic [15:0] exp_seq [10];
    logic [15:0] a;
    rst_n = 0; in_valid = 0; in_data = '0; in_sop = 0; in_eop = 0;
    in_mod = '0; in_chan = '0; in_err = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R10 reset state
    chk(lane_ctl == 1'b1 && lane_data == 16'h000F && in_ready == 1'b1, "R10",
        "reset idle", {15'd0, lane_ctl, lane_data}, {15'd0, 1'b1, 16'h000F});

    // example packet: three words, last with 3 valid bytes
    olog.delete();
    add(64'hF1E2_D3C4_B5A6_9F8E, 1, 0, 3'd0, 8'h02, 0);
    add(64'h1F2E_3D4C_5B6A_F9E8, 0, 0, 3'd0, 8'h02, 0);
    add(64'hABCD_1234_5678_9ABC, 0, 1, 3'd3, 8'h02, 0);
    drain();
    exp_seq = '{16'hF1E2, 16'hD3C4, 16'hB5A6, 16'h9F8E, 16'h1F2E,
                16'h3D4C, 16'h5B6A, 16'hF9E8, 16'hABCD, 16'h1200};
    i0 = find_hdr(12'h902);
    chk(i0 >= 0, "R3", "start word 902x present", 32'(i0), 0);
    if (i0 >= 0 && i0 + 11 < olog.size()) begin
      a = '0;
      for (int k = 0; k < 10; k++) begin
        chk(olog[i0+1+k] == {1'b0, exp_seq[k]}, (k < 8) ? "R1" : "R6",
            "payload order", 32'(olog[i0+1+k]), 32'({1'b0, exp_seq[k]}));
        a ^= exp_seq[k];
      end
      chk(olog[i0+11][16] && olog[i0+11][15:4] == 12'h602, "R5",
          "end word header", 32'(olog[i0+11]), 32'h1602);
      chk(olog[i0+11][3:0] == dip4(a ^ 16'h602F), "R8", "end word parity",
          32'(olog[i0+11][3:0]), 32'(dip4(a ^ 16'h602F)));
      chk(olog[i0][3:0] == dip4(16'h902F), "R8", "start word parity",
          32'(olog[i0][3:0]), 32'(dip4(16'h902F)));
    end
    chk(olog[olog.size()-1] == 17'h1000F, "R10", "idle after packet",
        32'(olog[olog.size()-1]), 32'h1000F);

    // back-to-back end then start: merged control word
    olog.delete();
    add(64'h0102_0304_0506_0708, 1, 1, 3'd0, 8'h05, 0);
    add(64'h1112_1314_1516_1718, 1, 1, 3'd2, 8'h07, 0);
    drain();
    chk(find_hdr(12'hD07) >= 0, "R9", "merged 10/start/ch07", 32'(find_hdr(12'hD07)), 0);
    chk(find_hdr(12'h407) >= 0, "R7", "two-byte end status", 32'(find_hdr(12'h407)), 0);

    // aborted packet
    olog.delete();
    add(64'h2222_3333_4444_5555, 1, 0, 3'd0, 8'h33, 0);
    add(64'h6666_7777_8888_9999, 0, 1, 3'd5, 8'h33, 1);
    drain();
    i1 = find_hdr(12'h233);
    chk(i1 >= 0, "R7", "abort end status", 32'(i1), 0);
    chk(i1 >= 3 && olog[i1-1] == 17'h08800 && olog[i1-2] == 17'h07777, "R6",
        "five bytes -> three lanes, pad", 32'(i1 >= 1 ? olog[i1-1] : 0), 32'h08800);

    // mixed traffic with source gaps, every byte count
    gaps = 1;
    for (int p = 0; p < 40; p++) begin
      int len = 1 + (p % 3);
      for (int w = 0; w < len; w++)
        add({32'(p * 32'h9E37_79B9), 32'(w * 32'h85EB_CA6B + p)}, w == 0, w == len - 1,
            3'(p % 8), 8'(p * 13), (p % 7) == 6);
      if ((p % 5) == 4) drain();
    end
    drain();
    report();
  end

endmodule